// File: doc/BRIEF.md
# Data-Strobe Serial Word Receiver

This block takes one serial channel carried on a data line and a strobe line and turns it into 32-bit words in the system clock domain. On this kind of link exactly one of the two lines changes for every bit. A bit boundary therefore shows up as a change in the exclusive-OR of the two lines, and the bit's value is the level of the data line after the change. The nominal line rate is 40 Mbit/s, so each 35-bit word takes 875 ns.

A local oversampling clock (`line_clk`, several times the bit rate) samples both lines through synchronizers and recovers the bit boundaries. A framer then hunts for a start bit, collects the payload, and checks the parity and stop bits. Checked words cross into the faster system clock through a four-entry asynchronous FIFO with Gray-coded pointers. They leave on a valid/ready interface, each with a parity-error flag attached. Framing errors and FIFO overflows are reported as sticky flags in the system domain.

Each frame is laid out as follows:
- a start bit of 1;
- 32 payload bits, most significant first;
- an odd-parity bit;
- a stop bit of 0.

Top module: `ds_word_rx`

## Requirements
- R1: A frame is accepted and its 32 payload bits appear on `out_data` with bit 31 first on the line. A frame is a start bit of 1, the 32 payload bits, a parity bit, and a stop bit of 0.
- R2: One bit is taken for each change of (`ds_data` XOR `ds_strobe`), and its value is the level of `ds_data` after the change. Intervals with no change add no bits.
- R3: Parity is odd. `out_perr` is 1 with a word when the payload plus the parity bit holds an even number of ones, and 0 otherwise. The payload is delivered in both cases.
- R4: A frame whose stop bit is 1 is dropped and sets `frame_err`, which stays at 1 until `sys_rst_n` is asserted. The next well-formed frame is still received.
- R5: While hunting, the receiver ignores bits of value 0. Line activity made only of 0 bits yields no word.
- R6: The FIFO holds four words. With `out_ready` held low, the first four frames are kept. Later frames are dropped and set the sticky `overflow` flag.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_perr` hold their values. A word is removed only on a cycle with both `out_valid` and `out_ready` at 1.
- R8: After reset, `out_valid`, `frame_err` and `overflow` are 0.
- R9: Words leave in the order their frames arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| line_clk | input | 1 | Oversampling clock for the serial side |
| line_rst_n | input | 1 | Synchronous active-low reset, line domain |
| ds_data | input | 1 | Serial data line |
| ds_strobe | input | 1 | Serial strobe line |
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Synchronous active-low reset, system domain |
| out_valid | output | 1 | A word is available |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_data | output | 32 | Received payload |
| out_perr | output | 1 | Parity error for the word on `out_data` |
| frame_err | output | 1 | Sticky: a frame with a bad stop bit was seen |
| overflow | output | 1 | Sticky: a frame was lost to a full FIFO |

## Verification
The assertions check the following on every cycle:
- the held output word stays stable under back-pressure;
- both error flags stay set once raised;
- 0 bits leave the hunting framer idle;
- a word is pushed only right after a recovered bit.

Whether the payload bits land in the right positions, whether parity is judged correctly, and what happens to dropped frames only show in the bench's scenarios. Those scenarios sweep a walking one through all 32 payload positions, send flipped parity, a bad stop bit and zero-only idle activity, and fill the FIFO past its depth.

// File: rtl/ds_rx_pkg.sv
`timescale 1ns/1ps
// Shared widths and word type for the data-strobe receiver.
package ds_rx_pkg;
    localparam int DATA_BITS  = 32;                  // payload width
    localparam int FRAME_BITS = DATA_BITS + 3;       // start + payload + parity + stop
    localparam int WORD_W     = DATA_BITS + 1;       // payload plus parity-error flag

    typedef struct packed {
        logic                 perr;
        logic [DATA_BITS-1:0] data;
    } ds_word_t;
endpackage

// File: rtl/ds_edge_recover.sv
`timescale 1ns/1ps
// Recovers bits from a data/strobe pair by oversampling with line_clk.
// Assumes line_clk is at least 3x the bit rate and the two lines are
// skew-matched to well under one line_clk period.
module ds_edge_recover (
    input  logic line_clk,
    input  logic line_rst_n,
    input  logic ds_data,
    input  logic ds_strobe,
    output logic bit_stb,
    output logic bit_val
);
    logic       d_meta, d_sync, s_meta, s_sync;
    logic       xor_prev;
    logic [1:0] warm;

    // Synchronize the lines, track the XOR and flag each change as a bit.
    always_ff @(posedge line_clk) begin
        if (!line_rst_n) begin
            d_meta   <= 1'b0;
            d_sync   <= 1'b0;
            s_meta   <= 1'b0;
            s_sync   <= 1'b0;
            xor_prev <= 1'b0;
            warm     <= 2'd0;
            bit_stb  <= 1'b0;
            bit_val  <= 1'b0;
        end else begin
            d_meta   <= ds_data;
            d_sync   <= d_meta;
            s_meta   <= ds_strobe;
            s_sync   <= s_meta;
            xor_prev <= d_sync ^ s_sync;
            if (warm != 2'd3)
                warm <= warm + 2'd1;
            bit_stb  <= (warm == 2'd3) && ((d_sync ^ s_sync) != xor_prev);
            bit_val  <= d_sync;
        end
    end
endmodule

// File: rtl/ds_word_framer.sv
`timescale 1ns/1ps
// Frames recovered bits into words: hunts for a start bit of 1, then takes
// 32 payload bits (MSB first), an odd-parity bit and a stop bit of 0.
// Bad stop drops the word and pulses frame_evt; parity travels with the word.
module ds_word_framer
    import ds_rx_pkg::*;
(
    input  logic     line_clk,
    input  logic     line_rst_n,
    input  logic     bit_stb,
    input  logic     bit_val,
    output logic     push,
    output ds_word_t push_word,
    output logic     frame_evt,
    output logic     busy
);
    localparam int CNT_W   = $clog2(DATA_BITS + 2);
    localparam int PAR_IDX = DATA_BITS;
    localparam int STP_IDX = DATA_BITS + 1;

    logic [CNT_W-1:0]     cnt;
    logic [DATA_BITS-1:0] shreg;
    logic                 par;

    // Frame state: hunt, then count payload, parity and stop positions.
    always_ff @(posedge line_clk) begin
        if (!line_rst_n) begin
            busy      <= 1'b0;
            cnt       <= '0;
            shreg     <= '0;
            par       <= 1'b0;
            push      <= 1'b0;
            push_word <= '0;
            frame_evt <= 1'b0;
        end else begin
            push      <= 1'b0;
            frame_evt <= 1'b0;
            if (bit_stb) begin
                if (!busy) begin
                    if (bit_val) begin
                        busy <= 1'b1;
                        cnt  <= '0;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                    if (cnt < CNT_W'(PAR_IDX)) begin
                        shreg <= {shreg[DATA_BITS-2:0], bit_val};
                    end else if (cnt == CNT_W'(PAR_IDX)) begin
                        par <= bit_val;
                    end else if (cnt == CNT_W'(STP_IDX)) begin
                        busy <= 1'b0;
                        if (!bit_val) begin
                            push           <= 1'b1;
                            push_word.data <= shreg;
                            push_word.perr <= ~(^shreg ^ par);
                        end else begin
                            frame_evt <= 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ds_async_fifo.sv
`timescale 1ns/1ps
// Asynchronous FIFO with Gray-coded pointers and two-flop pointer
// synchronizers. Show-ahead read. Assumes AW >= 2. A write while full is
// discarded and reported by wr_ovf one cycle later.
module ds_async_fifo #(
    parameter int W  = 33,
    parameter int AW = 2
) (
    input  logic         wr_clk,
    input  logic         wr_rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         wr_ovf,
    input  logic         rd_clk,
    input  logic         rd_rst_n,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         rd_empty
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_bin, wr_gray, rq1, rq2;
    logic [PW-1:0] rd_bin, rd_gray, wq1, wq2;
    logic          full;

    assign full     = (wr_gray == {~rq2[PW-1:PW-2], rq2[PW-3:0]});
    assign rd_empty = (rd_gray == wq2);
    assign rd_data  = mem[rd_bin[AW-1:0]];

    // Write pointer, read-pointer synchronizer and overflow report.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wr_bin  <= '0;
            wr_gray <= '0;
            rq1     <= '0;
            rq2     <= '0;
            wr_ovf  <= 1'b0;
        end else begin
            rq1    <= rd_gray;
            rq2    <= rq1;
            wr_ovf <= wr_en && full;
            if (wr_en && !full) begin
                wr_bin  <= wr_bin + 1'b1;
                wr_gray <= to_gray(wr_bin + 1'b1);
            end
        end
    end

    // Storage write, no reset needed.
    always_ff @(posedge wr_clk) begin
        if (wr_en && !full)
            mem[wr_bin[AW-1:0]] <= wr_data;
    end

    // Read pointer and write-pointer synchronizer.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_bin  <= '0;
            rd_gray <= '0;
            wq1     <= '0;
            wq2     <= '0;
        end else begin
            wq1 <= wr_gray;
            wq2 <= wq1;
            if (rd_en && !rd_empty) begin
                rd_bin  <= rd_bin + 1'b1;
                rd_gray <= to_gray(rd_bin + 1'b1);
            end
        end
    end
endmodule

// File: rtl/ds_pulse_sync.sv
`timescale 1ns/1ps
// Carries single-cycle event pulses across clock domains through a toggle.
// Assumes source pulses are spaced by more than three destination cycles.
module ds_pulse_sync (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic tog, q1, q2, q3;

    // Flip the toggle on each source event.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) tog <= 1'b0;
        else if (src_pulse) tog <= ~tog;
    end

    // Synchronize the toggle and keep one more stage for change detection.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            q1 <= 1'b0;
            q2 <= 1'b0;
            q3 <= 1'b0;
        end else begin
            q1 <= tog;
            q2 <= q1;
            q3 <= q2;
        end
    end

    assign dst_pulse = q2 ^ q3;
endmodule

// File: rtl/ds_word_rx.sv
`timescale 1ns/1ps
// Top level: data-strobe bit recovery and word framing in the line domain,
// handoff through a Gray-pointer FIFO, and sticky error flags in the system
// domain. Assumes line_clk oversamples the bit rate by 3x or more.
module ds_word_rx
    import ds_rx_pkg::*;
#(
    parameter int FIFO_AW = 2
) (
    input  logic                 line_clk,
    input  logic                 line_rst_n,
    input  logic                 ds_data,
    input  logic                 ds_strobe,
    input  logic                 sys_clk,
    input  logic                 sys_rst_n,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [DATA_BITS-1:0] out_data,
    output logic                 out_perr,
    output logic                 frame_err,
    output logic                 overflow
);
    logic     bit_stb, bit_val;
    logic     word_push, frame_evt, framer_busy;
    ds_word_t push_word, pop_word;
    logic     fifo_empty, ovf_evt;
    logic     frame_evt_sys, ovf_evt_sys;

    ds_edge_recover u_edge (
        .line_clk(line_clk), .line_rst_n(line_rst_n),
        .ds_data(ds_data), .ds_strobe(ds_strobe),
        .bit_stb(bit_stb), .bit_val(bit_val)
    );

    ds_word_framer u_framer (
        .line_clk(line_clk), .line_rst_n(line_rst_n),
        .bit_stb(bit_stb), .bit_val(bit_val),
        .push(word_push), .push_word(push_word),
        .frame_evt(frame_evt), .busy(framer_busy)
    );

    ds_async_fifo #(.W(WORD_W), .AW(FIFO_AW)) u_fifo (
        .wr_clk(line_clk), .wr_rst_n(line_rst_n),
        .wr_en(word_push), .wr_data(push_word), .wr_ovf(ovf_evt),
        .rd_clk(sys_clk), .rd_rst_n(sys_rst_n),
        .rd_en(out_ready), .rd_data(pop_word), .rd_empty(fifo_empty)
    );

    ds_pulse_sync u_frame_sync (
        .src_clk(line_clk), .src_rst_n(line_rst_n), .src_pulse(frame_evt),
        .dst_clk(sys_clk), .dst_rst_n(sys_rst_n), .dst_pulse(frame_evt_sys)
    );

    ds_pulse_sync u_ovf_sync (
        .src_clk(line_clk), .src_rst_n(line_rst_n), .src_pulse(ovf_evt),
        .dst_clk(sys_clk), .dst_rst_n(sys_rst_n), .dst_pulse(ovf_evt_sys)
    );

    assign out_valid = !fifo_empty;
    assign out_data  = pop_word.data;
    assign out_perr  = pop_word.perr;

    // Sticky error flags, cleared only by system reset.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            frame_err <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            frame_err <= frame_err | frame_evt_sys;
            overflow  <= overflow | ovf_evt_sys;
        end
    end
endmodule

// File: rtl/ds_word_rx_chk.sv
`timescale 1ns/1ps
// Property checker for ds_word_rx, bound to every instance of the top.
module ds_word_rx_chk (
    input logic        sys_clk,
    input logic        sys_rst_n,
    input logic        line_clk,
    input logic        line_rst_n,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        out_perr,
    input logic        frame_err,
    input logic        overflow,
    input logic        bit_stb,
    input logic        bit_val,
    input logic        framer_busy,
    input logic        word_push
);
    p_hold_word_r7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_perr)));

    p_frame_sticky_r4: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        frame_err |=> frame_err);

    p_ovf_sticky_r6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        overflow |=> overflow);

    p_hunt_ignores_zero_r5: assert property (@(posedge line_clk) disable iff (!line_rst_n)
        (!framer_busy && bit_stb && !bit_val) |=> !framer_busy);

    p_push_after_bit_r2: assert property (@(posedge line_clk) disable iff (!line_rst_n)
        word_push |-> $past(bit_stb));
endmodule

bind ds_word_rx ds_word_rx_chk u_chk (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
    .line_clk(line_clk), .line_rst_n(line_rst_n),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_perr(out_perr),
    .frame_err(frame_err), .overflow(overflow),
    .bit_stb(bit_stb), .bit_val(bit_val),
    .framer_busy(framer_busy), .word_push(word_push)
);

// File: tb/ds_word_rx_bench.sv
`timescale 1ns/1ps
module ds_word_rx_bench;
    localparam real CLK_PERIOD  = 4.0;    // system clock
    localparam real LINE_PERIOD = 5.0;    // oversampling clock, 5x bit rate
    localparam real BIT_NS      = 25.0;   // 40 Mbit/s
    localparam real GAP_NS      = 200.0;

    logic        line_clk = 1'b0, sys_clk = 1'b0;
    logic        line_rst_n = 1'b0, sys_rst_n = 1'b0;
    logic        ds_data = 1'b0, ds_strobe = 1'b0;
    logic        out_ready = 1'b1;
    logic        out_valid, out_perr, frame_err, overflow;
    logic [31:0] out_data;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [31:0] cap_data [256];
    logic        cap_perr [256];
    int          cap_n = 0;

    always #(CLK_PERIOD / 2.0)  sys_clk  = ~sys_clk;
    always #(LINE_PERIOD / 2.0) line_clk = ~line_clk;

    ds_word_rx u_ds_word_rx (
        .line_clk(line_clk), .line_rst_n(line_rst_n),
        .ds_data(ds_data), .ds_strobe(ds_strobe),
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_perr(out_perr),
        .frame_err(frame_err), .overflow(overflow)
    );

    // Record each word on the cycle it is taken.
    always @(negedge sys_clk) begin
        if (sys_rst_n && out_valid && out_ready && cap_n < 256) begin
            cap_data[cap_n] = out_data;
            cap_perr[cap_n] = out_perr;
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_ready(input logic v);
        @(posedge sys_clk);
        #1 out_ready = v;
    endtask

    task automatic do_reset();
        line_rst_n = 1'b0;
        sys_rst_n  = 1'b0;
        repeat (10) @(posedge sys_clk);
        #1;
        line_rst_n = 1'b1;
        sys_rst_n  = 1'b1;
        repeat (10) @(posedge sys_clk);
    endtask

    task automatic send_bit(input logic b);
        if (b == ds_data) ds_strobe = ~ds_strobe;
        ds_data = b;
        #(BIT_NS);
    endtask

    task automatic send_word(input logic [31:0] d, input bit bad_par, input logic stop);
        logic p;
        p = ~(^d);
        if (bad_par) p = ~p;
        send_bit(1'b1);
        for (int i = 31; i >= 0; i--) send_bit(d[i]);
        send_bit(p);
        send_bit(stop);
        #(GAP_NS);
    endtask

    function automatic logic [31:0] pattern(input int k);
        if (k < 32) return 32'h1 << k;
        case (k)
            32: return 32'h0000_0000;
            33: return 32'hFFFF_FFFF;
            34: return 32'hA5C3_0F96;
            default: return 32'h1357_9BDF ^ (k * 32'h0101_0101);
        endcase
    endfunction

    initial begin
        int base;
        do_reset();
        @(negedge sys_clk);
        check(out_valid == 1'b0, "R8 out_valid after reset", out_valid, 0);
        check(frame_err == 1'b0, "R8 frame_err after reset", frame_err, 0);
        check(overflow  == 1'b0, "R8 overflow after reset", overflow, 0);

        // R5: zero-only activity while hunting gives no word.
        for (int i = 0; i < 9; i++) send_bit(1'b0);
        #(GAP_NS);
        @(negedge sys_clk);
        check(cap_n == 0, "R5 zeros ignored while hunting", cap_n, 0);
        check(out_valid == 1'b0, "R5 no word pending after zeros", out_valid, 0);

        // R1, R2, R9: walking one and fixed patterns, arrival order preserved.
        base = cap_n;
        for (int k = 0; k < 38; k++) send_word(pattern(k), 1'b0, 1'b0);
        check(cap_n - base == 38, "R9 word count for sweep", cap_n - base, 38);
        for (int k = 0; k < 38; k++) begin
            check(cap_data[base + k] == pattern(k), "R1 payload", cap_data[base + k], pattern(k));
            check(cap_perr[base + k] == 1'b0, "R3 good parity flag", cap_perr[base + k], 0);
        end

        // R3: flipped parity still delivers payload with the error flag.
        base = cap_n;
        send_word(32'h0000_0001, 1'b1, 1'b0);
        send_word(32'h0000_0003, 1'b1, 1'b0);
        check(cap_n - base == 2, "R3 bad-parity words delivered", cap_n - base, 2);
        check(cap_data[base] == 32'h1 && cap_perr[base] == 1'b1, "R3 odd-weight word flagged",
              {cap_perr[base], cap_data[base]}, {1'b1, 32'h1});
        check(cap_data[base + 1] == 32'h3 && cap_perr[base + 1] == 1'b1, "R3 even-weight word flagged",
              {cap_perr[base + 1], cap_data[base + 1]}, {1'b1, 32'h3});

        // R4: bad stop bit drops the word and sets the sticky flag.
        base = cap_n;
        send_word(32'hDEAD_BEEF, 1'b0, 1'b1);
        @(negedge sys_clk);
        check(cap_n == base, "R4 bad-stop word dropped", cap_n - base, 0);
        check(frame_err == 1'b1, "R4 frame_err set", frame_err, 1);
        send_word(32'h0BAD_F00D, 1'b0, 1'b0);
        @(negedge sys_clk);
        check(cap_n - base == 1 && cap_data[base] == 32'h0BAD_F00D, "R4 resync after bad stop",
              cap_data[base], 32'h0BAD_F00D);
        check(frame_err == 1'b1, "R4 frame_err sticky", frame_err, 1);

        // R8: reset clears sticky flags; R6/R7: overflow under back-pressure.
        set_ready(1'b0);
        do_reset();
        @(negedge sys_clk);
        check(frame_err == 1'b0, "R8 frame_err cleared by reset", frame_err, 0);
        for (int k = 0; k < 6; k++) send_word(32'h1000_0000 + k, 1'b0, 1'b0);
        @(negedge sys_clk);
        check(overflow == 1'b1, "R6 overflow set", overflow, 1);
        check(out_valid == 1'b1 && out_data == 32'h1000_0000, "R7 head word held", out_data, 32'h1000_0000);
        repeat (20) @(negedge sys_clk);
        check(out_valid == 1'b1 && out_data == 32'h1000_0000, "R7 head word stable", out_data, 32'h1000_0000);
        base = cap_n;
        set_ready(1'b1);
        repeat (20) @(negedge sys_clk);
        check(cap_n - base == 4, "R6 four words kept", cap_n - base, 4);
        for (int k = 0; k < 4; k++)
            check(cap_data[base + k] == 32'h1000_0000 + k, "R9 order after overflow",
                  cap_data[base + k], 32'h1000_0000 + k);
        check(out_valid == 1'b0, "R6 extra words dropped", out_valid, 0);
        check(overflow == 1'b1, "R6 overflow sticky", overflow, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(2_000_000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule